// File: doc/BRIEF.md
# SMBus Block-Write Configuration Register Bank

This block holds twenty-one 8-bit configuration registers behind a byte-level SMBus slave front end. The front end handles the wire protocol and presents decoded events: start, stop, an address match with its direction bit, a received data byte, and a request for the next byte to transmit. The bank turns those events into register updates and read-back bytes. Its register contents are presented as one flat vector.

Writes use block-write framing only. The two bytes that follow the address are the command code and the byte count. Both are consumed and their values are dropped. Data bytes then fill registers from index 0 upward, and the host may stop after any whole byte. Registers 11/12 form a pair, and so do registers 13/14. A pair changes only when both of its bytes arrive in one transaction; otherwise neither register changes. Register 8 sets the read length. Register 7 carries a fixed vendor nibble and a revision nibble.

A read transaction first returns the read length, then registers 0, 1, 2 and so on until that many data bytes have been sent. After that it returns FFh.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, register 0 holds 00h, registers 1 to 6 hold FFh, register 7 holds {4'b1001, REV_ID}, register 8 holds 08h, register 9 holds 10h, and registers 10 to 20 hold 00h. regs_out[8*i+7:8*i] carries register i, and tx_byte holds FFh.
- R2: In a write transaction, the first two bytes after the address change no register. The third byte goes to register 0.
- R3: The k-th data byte (counting from 0) of a write transaction goes to register k. Bytes received before a stop are kept.
- R4: Registers 11 and 12 both load only when the bytes for 11 and 12 arrive in the same transaction. Registers 13 and 14 follow the same rule. Otherwise neither register of the pair changes.
- R5: A data byte of 00h aimed at register 8 is ignored, and the old value stays.
- R6: Writes to register 7 have no effect.
- R7: Data bytes beyond register 20 are accepted and discarded. No register changes because of them.
- R8: In a read transaction, tx_byte shows the byte for each request one cycle after the request. The first byte is register 8. The following bytes are registers 0, 1, ... up to the count held in register 8. Any later request returns FFh.
- R9: A start in the middle of a write drops any half-received pair and resets the byte pointer. The next write again begins with two discarded bytes and then register 0.
- R10: A data byte that arrives in the same cycle as a stop is still written. If that byte completes a pair, the pair commits.
- R11: Data bytes that arrive outside an addressed write transaction, including bytes during a read, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition seen on the bus |
| ev_stop | input | 1 | Stop condition seen on the bus |
| ev_addr | input | 1 | Own address matched (one-cycle pulse) |
| ev_dir_rd | input | 1 | Direction with ev_addr: 1 = read, 0 = write |
| ev_wr_vld | input | 1 | A received byte is on ev_wr_byte |
| ev_wr_byte | input | 8 | Received byte |
| ev_rd_req | input | 1 | Front end wants the next transmit byte |
| tx_byte | output | 8 | Transmit byte, updated the cycle after ev_rd_req |
| regs_out | output | 168 | All registers, register i in bits 8*i+7 down to 8*i |

## Verification
Two functions can land in the same clock cycle: the high byte of a pair being written, and the stop that ends the transaction. The bench raises ev_stop together with the last data byte in half of its write-length sweep. It does this on purpose for a write that ends exactly on register 12. A transaction that ends on the low byte of a pair in the same way must leave that pair unchanged. Every register is compared after each case against a model that applies the byte first and the stop second.

// File: rtl/cfgbank_pkg.sv
`timescale 1ns/1ps
package cfgbank_pkg;

    localparam int NREG   = 21;
    localparam int DW     = 8;
    localparam int IDX_W  = $clog2(NREG + 1);
    localparam int NPAIR  = 2;
    localparam int IDX_ID  = 7;
    localparam int IDX_CNT = 8;
    localparam int FIRST_PAIR = 11;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_CNT, PH_WDAT, PH_RHEAD, PH_RDAT
    } phase_t;

    typedef enum logic [1:0] {TX_NONE, TX_HEAD, TX_REG} txsrc_t;

    typedef enum logic [2:0] {RK_PLAIN, RK_FIXED, RK_COUNT, RK_PLO, RK_PHI} rkind_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } wr_evt_t;

    typedef struct packed {
        logic             req;
        txsrc_t           src;
        logic [IDX_W-1:0] idx;
    } rd_evt_t;

    function automatic int pair_lo(input int p);
        return FIRST_PAIR + 2 * p;
    endfunction

    function automatic int pair_of(input int i);
        return (i >= FIRST_PAIR + 2) ? 1 : 0;
    endfunction

    function automatic rkind_t kind_of(input int i);
        if (i == IDX_ID)                                   return RK_FIXED;
        if (i == IDX_CNT)                                  return RK_COUNT;
        if (i >= FIRST_PAIR && i < FIRST_PAIR + 2*NPAIR)
            return ((i - FIRST_PAIR) % 2 == 0) ? RK_PLO : RK_PHI;
        return RK_PLAIN;
    endfunction

    function automatic logic [DW-1:0] dflt_of(input int i, input logic [3:0] rev);
        if (i >= 1 && i <= 6) return 8'hFF;
        if (i == IDX_ID)      return {4'b1001, rev};
        if (i == IDX_CNT)     return 8'h08;
        if (i == 9)           return 8'h10;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfgbank_seq.sv
`timescale 1ns/1ps
module cfgbank_seq
    import cfgbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_addr,
    input  logic          ev_dir_rd,
    input  logic          ev_wr_vld,
    input  logic [DW-1:0] ev_wr_byte,
    input  logic          ev_rd_req,
    input  logic [DW-1:0] rd_count,
    output wr_evt_t       wr,
    output rd_evt_t       rd,
    output logic          abort
);

    localparam logic [IDX_W-1:0] NREG_I = IDX_W'(NREG);
    localparam logic [DW-1:0]    NREG_B = DW'(NREG);

    phase_t           ph;
    logic [IDX_W-1:0] wptr;
    logic [DW-1:0]    sent;

    always_comb begin
        wr.vld  = ev_wr_vld && !ev_start && (ph == PH_WDAT) && (wptr < NREG_I);
        wr.idx  = wptr;
        wr.data = ev_wr_byte;
        rd.req  = ev_rd_req;
        rd.idx  = sent[IDX_W-1:0];
        rd.src  = TX_NONE;
        if (ev_rd_req && !ev_start) begin
            if (ph == PH_RHEAD)
                rd.src = TX_HEAD;
            else if (ph == PH_RDAT && sent < rd_count && sent < NREG_B)
                rd.src = TX_REG;
        end
        abort = ev_start || ev_stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            wptr <= '0;
            sent <= '0;
        end else if (ev_start || ev_stop) begin
            ph   <= PH_IDLE;
            wptr <= '0;
            sent <= '0;
        end else if (ev_addr) begin
            ph   <= ev_dir_rd ? PH_RHEAD : PH_CMD;
            wptr <= '0;
            sent <= '0;
        end else begin
            case (ph)
                PH_CMD:   if (ev_wr_vld) ph <= PH_CNT;
                PH_CNT:   if (ev_wr_vld) ph <= PH_WDAT;
                PH_WDAT:  if (ev_wr_vld && wptr != NREG_I) wptr <= wptr + 1'b1;
                PH_RHEAD: if (ev_rd_req) ph <= PH_RDAT;
                PH_RDAT:  if (ev_rd_req && sent != 8'hFF) sent <= sent + 1'b1;
                default:  ;
            endcase
        end
    end

    // R9
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (ph == PH_IDLE && wptr == '0));

endmodule

// File: rtl/cfgbank_regs.sv
`timescale 1ns/1ps
module cfgbank_regs
    import cfgbank_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h2
)(
    input  logic          clk,
    input  logic          rst,
    input  wr_evt_t       wr,
    input  logic          abort,
    output logic [DW-1:0] r [NREG]
);

    logic [NPAIR-1:0] commit;
    logic [DW-1:0]    stg_v [NPAIR];
    logic             rdy;

    always_ff @(posedge clk) begin
        if (rst) rdy <= 1'b0;
        else     rdy <= 1'b1;
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = pair_lo(p);
        logic [DW-1:0] held;
        logic          got_lo;

        always_ff @(posedge clk) begin
            if (rst || abort) begin
                held   <= '0;
                got_lo <= 1'b0;
            end else if (wr.vld && wr.idx == IDX_W'(LO)) begin
                held   <= wr.data;
                got_lo <= 1'b1;
            end
        end

        assign stg_v[p]  = held;
        assign commit[p] = wr.vld && (wr.idx == IDX_W'(LO + 1)) && got_lo;

        // R4
        pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (rdy && r[LO] != $past(r[LO])) |-> $past(wr.vld && wr.idx == IDX_W'(LO + 1)));
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam rkind_t        K  = kind_of(i);
        localparam logic [DW-1:0] DV = dflt_of(i, REV_ID);
        localparam int            P  = pair_of(i);

        if (K == RK_FIXED) begin : g_fix
            assign r[i] = DV;
        end else begin : g_rw
            logic [DW-1:0] q;
            logic          hit;
            assign hit = wr.vld && (wr.idx == IDX_W'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= DV;
                end else begin
                    case (K)
                        RK_PLAIN: if (hit) q <= wr.data;
                        RK_COUNT: if (hit && wr.data != 8'h00) q <= wr.data;
                        RK_PLO:   if (commit[P]) q <= stg_v[P];
                        RK_PHI:   if (commit[P]) q <= wr.data;
                        default:  ;
                    endcase
                end
            end
            assign r[i] = q;
        end
    end

    // R5
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> r[IDX_CNT] != 8'h00);

endmodule

// File: rtl/cfgbank_tx.sv
`timescale 1ns/1ps
module cfgbank_tx
    import cfgbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  rd_evt_t       rd,
    input  logic [DW-1:0] r [NREG],
    output logic [DW-1:0] tx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= 8'hFF;
        end else if (rd.req) begin
            case (rd.src)
                TX_HEAD: tx <= r[IDX_CNT];
                TX_REG:  tx <= r[rd.idx];
                default: tx <= 8'hFF;
            endcase
        end
    end

    // R8
    pad_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (rd.req && rd.src == TX_NONE) |=> tx == 8'hFF);

    // R8
    head_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (rd.req && rd.src == TX_HEAD) |=> tx == $past(r[IDX_CNT]));

endmodule

// File: rtl/cfg_regbank.sv
`timescale 1ns/1ps
module cfg_regbank
    import cfgbank_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               ev_addr,
    input  logic               ev_dir_rd,
    input  logic               ev_wr_vld,
    input  logic [DW-1:0]      ev_wr_byte,
    input  logic               ev_rd_req,
    output logic [DW-1:0]      tx_byte,
    output logic [NREG*DW-1:0] regs_out
);

    wr_evt_t       wr;
    rd_evt_t       rd;
    logic          abort;
    logic [DW-1:0] r [NREG];

    cfgbank_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_addr   (ev_addr),
        .ev_dir_rd (ev_dir_rd),
        .ev_wr_vld (ev_wr_vld),
        .ev_wr_byte(ev_wr_byte),
        .ev_rd_req (ev_rd_req),
        .rd_count  (r[IDX_CNT]),
        .wr        (wr),
        .rd        (rd),
        .abort     (abort)
    );

    cfgbank_regs #(.REV_ID(REV_ID)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .abort(abort),
        .r    (r)
    );

    cfgbank_tx u_tx (
        .clk(clk),
        .rst(rst),
        .rd (rd),
        .r  (r),
        .tx (tx_byte)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_flat
        assign regs_out[i*DW +: DW] = r[i];
    end

endmodule

// File: tb/tb_cfg_regbank.sv
`timescale 1ns/1ps
module tb_cfg_regbank;

    localparam logic [3:0] REV = 4'h2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst, ev_start, ev_stop, ev_addr, ev_dir_rd, ev_wr_vld, ev_rd_req;
    logic [7:0]   ev_wr_byte, tx_byte;
    logic [167:0] regs_out;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_r [21];
    logic [7:0] stg_v [2];
    bit         stg_ok [2];
    bit         m_wr;
    int         m_hdr, m_ptr;

    cfg_regbank #(.REV_ID(REV)) dut (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_addr(ev_addr), .ev_dir_rd(ev_dir_rd), .ev_wr_vld(ev_wr_vld),
        .ev_wr_byte(ev_wr_byte), .ev_rd_req(ev_rd_req),
        .tx_byte(tx_byte), .regs_out(regs_out)
    );

    task automatic chk(input string tag, input int act, input int ex);
        total++;
        if (act != ex) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, ex);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 21; i++) begin
            if (i == 0)      exp_r[i] = 8'h00;
            else if (i <= 6) exp_r[i] = 8'hFF;
            else if (i == 7) exp_r[i] = {4'b1001, REV};
            else if (i == 8) exp_r[i] = 8'h08;
            else if (i == 9) exp_r[i] = 8'h10;
            else             exp_r[i] = 8'h00;
        end
        stg_ok[0] = 0; stg_ok[1] = 0; m_wr = 0;
    endtask

    task automatic m_abort();
        stg_ok[0] = 0; stg_ok[1] = 0; m_wr = 0;
    endtask

    task automatic m_apply(input int idx, input logic [7:0] v);
        int p;
        p = (idx >= 13) ? 1 : 0;
        if (idx > 20 || idx == 7) return;
        if (idx == 8) begin
            if (v != 8'h00) exp_r[8] = v;
        end else if (idx == 11 || idx == 13) begin
            stg_v[p] = v; stg_ok[p] = 1;
        end else if (idx == 12 || idx == 14) begin
            if (stg_ok[p]) begin
                exp_r[idx-1] = stg_v[p];
                exp_r[idx]   = v;
            end
        end else begin
            exp_r[idx] = v;
        end
    endtask

    task automatic do_rst();
        rst = 1; ev_start = 0; ev_stop = 0; ev_addr = 0; ev_dir_rd = 0;
        ev_wr_vld = 0; ev_rd_req = 0; ev_wr_byte = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_reset();
    endtask

    task automatic do_start();
        @(negedge clk) ev_start = 1;
        @(negedge clk) ev_start = 0;
        m_abort();
    endtask

    task automatic do_stop();
        @(negedge clk) ev_stop = 1;
        @(negedge clk) ev_stop = 0;
        m_abort();
    endtask

    task automatic do_addr(input bit rd);
        @(negedge clk) begin ev_addr = 1; ev_dir_rd = rd; end
        @(negedge clk) ev_addr = 0;
        m_wr = !rd; m_hdr = 0; m_ptr = 0;
    endtask

    task automatic send(input logic [7:0] v, input bit with_stop);
        @(negedge clk) begin ev_wr_vld = 1; ev_wr_byte = v; ev_stop = with_stop; end
        @(negedge clk) begin ev_wr_vld = 0; ev_stop = 0; end
        if (m_wr) begin
            if (m_hdr < 2) m_hdr++;
            else begin m_apply(m_ptr, v); m_ptr++; end
        end
        if (with_stop) m_abort();
    endtask

    task automatic cmp_all(input string ovr);
        string tag;
        for (int i = 0; i < 21; i++) begin
            if (ovr != "")               tag = ovr;
            else if (i == 0)             tag = "R2";
            else if (i == 7)             tag = "R6";
            else if (i == 8)             tag = "R5";
            else if (i >= 11 && i <= 14) tag = "R4";
            else                         tag = "R3";
            chk(tag, int'(regs_out[i*8 +: 8]), int'(exp_r[i]));
        end
    endtask

    // R8: count first, then registers 0.., then FFh padding
    task automatic read_txn(input int nreq);
        int ex;
        do_start();
        do_addr(1);
        for (int k = 0; k < nreq; k++) begin
            @(negedge clk) ev_rd_req = 1;
            @(negedge clk) ev_rd_req = 0;
            if (k == 0)                                ex = exp_r[8];
            else if (k <= int'(exp_r[8]) && k - 1 < 21) ex = exp_r[k-1];
            else                                       ex = 8'hFF;
            chk("R8", int'(tx_byte), ex);
        end
        do_stop();
    endtask

    function automatic logic [7:0] pat(input int seed, input int i, input int n);
        return 8'((seed * 83 + i * 29 + n * 7 + 1) & 255);
    endfunction

    task automatic write_txn(input int n, input int seed, input bit last_stop);
        do_start();
        do_addr(0);
        send(8'hC3, 0);
        send(8'(n), 0);
        for (int i = 0; i < n; i++)
            send(pat(seed, i, n), last_stop && (i == n - 1));
        if (!last_stop || n == 0) do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_rst();
        // R1 reset contents and idle transmit byte
        cmp_all("R1");
        chk("R1", int'(tx_byte), 8'hFF);
        // R8 default readback: 8 bytes plus padding
        read_txn(11);

        // R3 R4 R7 R10: sweep of write lengths, stop separate or with last byte
        for (int n = 0; n <= 24; n++) begin
            for (int seed = 0; seed < 2; seed++) begin
                write_txn(n, seed + n, seed[0]);
                cmp_all(n > 21 ? "R7" : "");
                read_txn(int'(exp_r[8]) + 2);
            end
        end

        // R10: pair high byte together with stop commits the pair
        write_txn(13, 9, 1);
        chk("R10", int'(regs_out[11*8 +: 8]), int'(pat(9, 11, 13)));
        chk("R10", int'(regs_out[12*8 +: 8]), int'(pat(9, 12, 13)));
        // R10: pair low byte together with stop leaves pair alone
        write_txn(14, 11, 1);
        cmp_all("R10");

        // R5: 00h to register 8 ignored
        do_start(); do_addr(0); send(8'h01, 0); send(8'h09, 0);
        for (int i = 0; i < 9; i++) send((i == 8) ? 8'h00 : 8'(8'h40 + i), 0);
        do_stop();
        cmp_all("");
        chk("R5", int'(regs_out[8*8 +: 8]), int'(exp_r[8]));

        // R6: write to register 7 attempted
        do_start(); do_addr(0); send(8'h00, 0); send(8'h08, 0);
        for (int i = 0; i < 8; i++) send(8'h5C, 0);
        do_stop();
        chk("R6", int'(regs_out[7*8 +: 8]), int'({4'b1001, REV}));

        // R9: start mid-write drops staged low byte and resets pointer
        do_start(); do_addr(0); send(8'hAA, 0); send(8'h20, 0);
        for (int i = 0; i < 12; i++) send(8'(8'h70 + i), 0);
        do_start(); do_addr(0); send(8'hAA, 0); send(8'h01, 0); send(8'h5A, 0);
        do_stop();
        chk("R9", int'(regs_out[0 +: 8]), 8'h5A);
        chk("R9", int'(regs_out[11*8 +: 8]), int'(exp_r[11]));
        cmp_all("R9");

        // R11: bytes with no transaction, and bytes during a read
        send(8'h33, 0); send(8'h44, 0); send(8'h55, 0);
        cmp_all("R11");
        do_start(); do_addr(1); send(8'h66, 0); send(8'h77, 0); send(8'h88, 0);
        do_stop();
        cmp_all("R11");

        // R1: reset restores defaults after writes
        do_rst();
        cmp_all("R1");
        read_txn(10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule